// File: doc/BRIEF.md
# Watchdog and Alarm Countdown Timer

This block is a 24-bit down-counter with two personalities. As a repeating alarm it counts down once per 1 Hz tick. At zero it raises a sticky flag, reloads its seed and carries on. As a one-shot watchdog it counts down on a 4096 Hz tick and stops at zero. The host must keep restarting it by reading a seed byte, writing the seed, or raising the strobe input. If the watchdog runs out with its interrupt armed, the block drives its active-low open-drain interrupt for a fixed 1024 fast ticks, which is 250 ms. This pulse cannot be cut short. The flag clears itself when the pulse ends.

The host sees five byte registers on a simple bus with one-cycle write and read strobes:

| Address | Contents |
|---|---|
| 0 | Seed, least significant byte |
| 1 | Seed, middle byte |
| 2 | Seed, most significant byte |
| 3 | Control |
| 4 | Status |

The control bits are:

| Bit | Name | Meaning |
|---|---|---|
| 0 | run enable | Counter may run |
| 1 | mode | 1 = watchdog, 0 = alarm |
| 2 | interrupt select | Part of the interrupt arming |
| 3 | interrupt enable | Part of the interrupt arming |

The status register holds the expiry flag in bit 0. A read always returns the stored seed, never the live count. While the counter is stopped, the 24 seed bits act as plain storage.

The control logic is a four-state machine:

| State | Meaning |
|---|---|
| OFF | Not counting |
| COUNT | Decrementing |
| EXPIRED | Watchdog reached zero; held at zero |
| PULSE | Timed interrupt pulse in progress |

The transitions are:

- **arm**: OFF to COUNT, on a control write that raises run enable while the seed is nonzero.
- **drop**: any state except PULSE to OFF, when enable is cleared or the seed becomes zero.
- **alarm wrap**: COUNT to COUNT at zero in alarm mode.
- **silent expiry**: COUNT to EXPIRED, in watchdog mode with the interrupt not armed.
- **pulse expiry**: COUNT to PULSE, in watchdog mode with the interrupt armed.
- **restart**: EXPIRED to COUNT, on any reload event.
- **pulse end**: PULSE to COUNT, EXPIRED or OFF after 1024 fast ticks. The choice depends on pending reloads and on enable.

Top module: `wdalm_timer`

## Requirements
- R1: After reset, all seed bytes, control and status read 0 and `irq_pull` is 0.
- R2: Seed bytes at addresses 0 (LSB), 1 and 2 (MSB) and control bits [3:0] at address 3 read back what was written. With run enable 0, ticks never set the flag (status bit 0).
- R3: Writing the seed to all zero stops the counter, whatever the run-enable bit holds.
- R4: Counting starts only on a control write that changes run enable from 0 to 1 while the seed is nonzero. A seed changed from zero to nonzero with enable already 1 stays stopped.
- R5: In alarm mode (control bit 1 = 0), a seed of N sets the flag on the N-th 1 Hz tick, reloads, and sets it again every N ticks.
- R6: The flag is cleared only by writing status bit 0 as 0; writing it as 1 leaves it unchanged.
- R7: In alarm mode, `irq_pull` is 1 exactly while the flag is 1 and control bits 2 and 3 are both 1.
- R8: In watchdog mode (control bit 1 = 1), a seed of N sets the flag on the N-th 4096 Hz tick and the counter then stops.
- R9: In watchdog mode, reading a seed byte, writing a seed byte, or a rising edge on `wd_strobe` reloads the count from the seed and restarts it. The strobe passes through a two-flop synchroniser first.
- R10: If control bits 2 and 3 are both 1 at watchdog expiry, `irq_pull` is 1 for exactly 1024 ticks of the 4096 Hz input. At the end of that pulse the flag clears and `irq_pull` returns to 0.
- R11: Writing the flag or interrupt enable to 0 during the pulse neither shortens the pulse nor clears the flag early.
- R12: A seed write during the pulse loads the new seed. Counting from that seed begins only after the pulse ends.
- R13: A watchdog expiry with the interrupt not armed sets the flag but leaves `irq_pull` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_1hz | input | 1 | One-cycle enable once per second |
| tick_4khz | input | 1 | One-cycle enable at 4096 Hz |
| wd_strobe | input | 1 | Asynchronous watchdog restart strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
A corrupt down-count shows up as the flag rising on the wrong tick. In alarm mode that is visible within one period of N slow ticks. In watchdog mode it is visible within N fast ticks, or as a restart that fails to delay expiry. A wrong state register shows as `irq_pull` asserting without a pulse, or as a pulse that does not last exactly 1024 fast ticks. The flag clearing at the wrong moment relative to the pulse edge would also expose it. All of these are observable at the status read or on `irq_pull` no later than one pulse length after the fault.

// File: rtl/wdalm_pkg.sv
package wdalm_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_COUNT,
        ST_EXPIRED,
        ST_PULSE
    } wd_state_e;

    // control register layout, bit 3 down to bit 0
    typedef struct packed {
        logic irq_en;
        logic irq_sel;
        logic wd_mode;
        logic run_en;
    } ctrl_t;

    localparam int ADDR_CTRL = 3;
    localparam int ADDR_STAT = 4;
endpackage

// File: rtl/wdalm_edge_sync.sv
module wdalm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], async_in};
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/wdalm_pulse_timer.sv
module wdalm_pulse_timer #(
    parameter int TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic          active;
    logic [CW-1:0] cnt;

    assign done = active && tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (done) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active && tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdalm_fsm.sv
module wdalm_fsm
    import wdalm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_slow,
    input  logic             tick_fast,
    input  ctrl_t            ctrl_nx,
    input  logic [CNT_W-1:0] seed_nx,
    input  logic             seed_wr,
    input  logic             en_rise,
    input  logic             cnt_rd,
    input  logic             strobe_rise,
    input  logic             pulse_done,
    output wd_state_e        state,
    output logic             expire,
    output logic             pulse_start,
    output logic             in_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wd_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pend_q, pend_d;
    logic             fire, go_pulse;

    logic wd, step, keep_on, reload, armed;
    assign wd      = ctrl_nx.wd_mode;
    assign step    = wd ? tick_fast : tick_slow;
    assign keep_on = ctrl_nx.run_en && (seed_nx != '0);
    assign reload  = seed_wr || (wd && (cnt_rd || strobe_rise));
    assign armed   = ctrl_nx.irq_sel && ctrl_nx.irq_en;

    // next-state and count logic
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        pend_d   = pend_q;
        fire     = 1'b0;
        go_pulse = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                if (en_rise && seed_nx != '0) begin
                    st_d  = ST_COUNT;
                    cnt_d = seed_nx;
                end
            end
            ST_COUNT: begin
                if (!keep_on) begin
                    st_d = ST_OFF;
                end else if (reload) begin
                    cnt_d = seed_nx;
                end else if (step) begin
                    if (cnt_q == ONE) begin
                        fire = 1'b1;
                        if (!wd) begin
                            cnt_d = seed_nx;
                        end else begin
                            cnt_d = '0;
                            if (armed) begin
                                st_d     = ST_PULSE;
                                go_pulse = 1'b1;
                                pend_d   = 1'b0;
                            end else begin
                                st_d = ST_EXPIRED;
                            end
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_EXPIRED: begin
                if (!keep_on) begin
                    st_d = ST_OFF;
                end else if (reload) begin
                    st_d  = ST_COUNT;
                    cnt_d = seed_nx;
                end
            end
            ST_PULSE: begin
                if (reload) begin
                    cnt_d  = seed_nx;
                    pend_d = 1'b1;
                end
                if (pulse_done) begin
                    if (!keep_on)              st_d = ST_OFF;
                    else if (pend_q || reload) st_d = ST_COUNT;
                    else                       st_d = ST_EXPIRED;
                end
            end
            default: st_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    // outputs
    always_comb begin
        state       = st_q;
        expire      = fire;
        pulse_start = go_pulse;
        in_pulse    = (st_q == ST_PULSE);
    end
endmodule

// File: rtl/wdalm_timer.sv
module wdalm_timer
    import wdalm_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int PULSE_TICKS = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       tick_4khz,
    input  logic       wd_strobe,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq_pull
);
    localparam int NBYTES = CNT_W / 8;

    logic [CNT_W-1:0] seed_q, seed_nx;
    ctrl_t            ctrl_q, ctrl_nx;
    logic             flag_q, flag_d;

    logic wr_ctrl, wr_stat, seed_wr, cnt_rd, en_rise;
    logic strobe_rise, pulse_done, pulse_start, expire, in_pulse;
    wd_state_e fsm_state;
    logic [3:0] unused_wr_hi;

    assign wr_ctrl = wr_en && (addr == 3'(ADDR_CTRL));
    assign wr_stat = wr_en && (addr == 3'(ADDR_STAT));
    assign seed_wr = wr_en && (int'(addr) < NBYTES);
    assign cnt_rd  = rd_en && (int'(addr) < NBYTES);
    assign ctrl_nx = wr_ctrl ? ctrl_t'(wr_data[3:0]) : ctrl_q;
    assign en_rise = wr_ctrl && wr_data[0] && !ctrl_q.run_en;
    assign unused_wr_hi = wr_data[7:4];

    for (genvar b = 0; b < NBYTES; b++) begin : g_seed
        assign seed_nx[b*8 +: 8] = (wr_en && int'(addr) == b) ? wr_data
                                                              : seed_q[b*8 +: 8];
    end

    always_comb begin
        flag_d = flag_q;
        if (wr_stat && !wr_data[0] && !in_pulse) flag_d = 1'b0;
        if (pulse_done)                          flag_d = 1'b0;
        if (expire)                              flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= '0;
            ctrl_q <= '0;
            flag_q <= 1'b0;
        end else begin
            seed_q <= seed_nx;
            ctrl_q <= ctrl_nx;
            flag_q <= flag_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(addr) < NBYTES) rd_data = seed_q[int'(addr)*8 +: 8];
        else if (addr == 3'(ADDR_CTRL)) rd_data = {4'b0, ctrl_q};
        else if (addr == 3'(ADDR_STAT)) rd_data = {7'b0, flag_q};
    end

    assign irq_pull = in_pulse ||
                      (!ctrl_q.wd_mode && flag_q && ctrl_q.irq_sel && ctrl_q.irq_en);

    wdalm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(wd_strobe), .rise(strobe_rise)
    );

    wdalm_pulse_timer #(.TICKS(PULSE_TICKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(pulse_start), .tick(tick_4khz),
        .done(pulse_done)
    );

    wdalm_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_slow(tick_1hz), .tick_fast(tick_4khz),
        .ctrl_nx(ctrl_nx), .seed_nx(seed_nx), .seed_wr(seed_wr),
        .en_rise(en_rise), .cnt_rd(cnt_rd), .strobe_rise(strobe_rise),
        .pulse_done(pulse_done), .state(fsm_state), .expire(expire),
        .pulse_start(pulse_start), .in_pulse(in_pulse)
    );
endmodule

// File: rtl/wdalm_checker.sv
module wdalm_checker
    import wdalm_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int PULSE_TICKS = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_fast,
    input logic             in_pulse,
    input logic             pulse_done,
    input logic             flag_q,
    input logic             irq_pull,
    input logic             clr_write,
    input logic [CNT_W-1:0] seed_q,
    input wd_state_e        fsm_state
);
    localparam int PCW = $clog2(PULSE_TICKS) + 1;
    localparam logic [PCW-1:0] LAST = PCW'(PULSE_TICKS - 1);

    logic [PCW-1:0] pcnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pcnt <= '0;
        else if (!in_pulse)        pcnt <= '0;
        else if (tick_fast)        pcnt <= pcnt + 1'b1;
    end

    a_r10_pulse_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
        in_pulse |-> irq_pull);

    a_r10_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pulse && tick_fast && pcnt == LAST) |=> !in_pulse);

    a_r11_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pulse && !(tick_fast && pcnt == LAST)) |=> in_pulse);

    a_r10_flag_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_pulse) |-> !flag_q);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_write && !pulse_done) |=> flag_q);

    a_r3_zero_seed_off: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_q == '0 && fsm_state != ST_PULSE) |-> fsm_state == ST_OFF);
endmodule

bind wdalm_timer wdalm_checker #(.CNT_W(CNT_W), .PULSE_TICKS(PULSE_TICKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_4khz), .in_pulse(in_pulse),
    .pulse_done(pulse_done), .flag_q(flag_q), .irq_pull(irq_pull),
    .clr_write(wr_stat && !wr_data[0]), .seed_q(seed_q), .fsm_state(fsm_state)
);

// File: tb/wdalm_timer_test.sv
module wdalm_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0, tick_4khz = 1'b0, wd_strobe = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_pull;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    wdalm_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_4khz(tick_4khz),
        .wd_strobe(wd_strobe), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_pull(irq_pull)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = 3'(a); wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = 3'(a); #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic peek(input int a, output logic [7:0] d);
        @(negedge clk); addr = 3'(a); #1 d = rd_data;
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic fast(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_4khz = 1'b1;
            @(negedge clk); tick_4khz = 1'b0;
        end
    endtask

    task automatic set_seed(input logic [23:0] s);
        wr(0, s[7:0]); wr(1, s[15:8]); wr(2, s[23:16]);
    endtask

    task automatic flag_is(input string req, input logic e);
        logic [7:0] d;
        peek(4, d);
        check(req, {31'b0, d[0]}, {31'b0, e});
    endtask

    task automatic start(input logic [23:0] s, input logic [7:0] c);
        wr(3, 8'h00); wr(4, 8'h00); set_seed(s); wr(3, c);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 5; a++) begin
            peek(a, d);
            check("R1 reg reset", {24'b0, d}, 32'h0);
        end
        check("R1 irq reset", {31'b0, irq_pull}, 32'h0);
    endtask

    task automatic t_storage;
        logic [7:0] d;
        set_seed(24'h013CA5);
        rd(0, d); check("R2 seed byte0", {24'b0, d}, 32'hA5);
        rd(1, d); check("R2 seed byte1", {24'b0, d}, 32'h3C);
        rd(2, d); check("R2 seed byte2", {24'b0, d}, 32'h01);
        wr(3, 8'h0C);
        rd(3, d); check("R2 ctrl readback", {24'b0, d}, 32'h0C);
        set_seed(24'h000002);
        slow(5); fast(5);
        flag_is("R2 disabled no flag", 1'b0);
    endtask

    task automatic t_alarm;
        start(24'd3, 8'h0D);
        slow(2);
        flag_is("R5 not yet", 1'b0);
        check("R7 irq idle", {31'b0, irq_pull}, 32'h0);
        slow(1);
        flag_is("R5 first expiry", 1'b1);
        check("R7 irq on flag", {31'b0, irq_pull}, 32'h1);
        wr(4, 8'h01);
        flag_is("R6 write 1 keeps flag", 1'b1);
        wr(4, 8'h00);
        flag_is("R6 write 0 clears", 1'b0);
        check("R7 irq follows flag", {31'b0, irq_pull}, 32'h0);
        slow(2);
        flag_is("R5 reload not yet", 1'b0);
        slow(1);
        flag_is("R5 repeat expiry", 1'b1);
        wr(3, 8'h05);
        check("R7 irq needs enable", {31'b0, irq_pull}, 32'h0);
    endtask

    task automatic t_zero_and_arm;
        start(24'd2, 8'h01);
        set_seed(24'd0);
        wr(4, 8'h00);
        slow(4);
        flag_is("R3 zero seed stops", 1'b0);
        set_seed(24'd2);
        slow(4);
        flag_is("R4 no toggle stays stopped", 1'b0);
        wr(3, 8'h00); wr(3, 8'h01);
        slow(1);
        flag_is("R4 toggle started", 1'b0);
        slow(1);
        flag_is("R4 runs after toggle", 1'b1);
    endtask

    task automatic t_watchdog;
        logic [7:0] d;
        start(24'd5, 8'h03);
        fast(4);
        flag_is("R8 not yet", 1'b0);
        fast(1);
        flag_is("R8 expiry", 1'b1);
        check("R13 no irq", {31'b0, irq_pull}, 32'h0);
        wr(4, 8'h00);
        fast(12);
        flag_is("R8 stopped at zero", 1'b0);
        rd(0, d);
        fast(3);
        rd(1, d);
        fast(4);
        flag_is("R9 read reloads", 1'b0);
        fast(1);
        flag_is("R9 read restart expiry", 1'b1);
        wr(4, 8'h00);
        @(negedge clk); wd_strobe = 1'b1;
        repeat (5) @(negedge clk);
        fast(4);
        flag_is("R9 strobe restart", 1'b0);
        fast(1);
        flag_is("R9 strobe expiry", 1'b1);
        wr(4, 8'h00);
        wd_strobe = 1'b0;
        wr(0, 8'h05);
        fast(3);
        wr(0, 8'h05);
        fast(4);
        flag_is("R9 write reloads", 1'b0);
        fast(1);
        flag_is("R9 write restart expiry", 1'b1);
    endtask

    task automatic t_pulse;
        start(24'd2, 8'h0F);
        fast(2);
        flag_is("R10 flag at expiry", 1'b1);
        check("R10 pulse start", {31'b0, irq_pull}, 32'h1);
        fast(1000);
        wr(4, 8'h00);
        wr(3, 8'h07);
        flag_is("R11 flag kept", 1'b1);
        check("R11 pulse kept", {31'b0, irq_pull}, 32'h1);
        fast(23);
        check("R10 pulse at 1023", {31'b0, irq_pull}, 32'h1);
        fast(1);
        check("R10 pulse ended", {31'b0, irq_pull}, 32'h0);
        flag_is("R10 flag self clear", 1'b0);
    endtask

    task automatic t_pulse_write;
        start(24'd2, 8'h0F);
        fast(2);
        check("R12 pulse on", {31'b0, irq_pull}, 32'h1);
        wr(0, 8'h03);
        fast(1024);
        check("R12 pulse full length", {31'b0, irq_pull}, 32'h0);
        flag_is("R12 flag cleared", 1'b0);
        fast(2);
        flag_is("R12 counting new seed", 1'b0);
        fast(1);
        flag_is("R12 expiry after resume", 1'b1);
        check("R12 second pulse", {31'b0, irq_pull}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_storage();
        t_alarm();
        t_zero_and_arm();
        t_watchdog();
        t_pulse();
        t_pulse_write();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule